// File: doc/BRIEF.md
# Serial Peripheral Master Byte Engine

This block drives a four-wire serial peripheral bus as the clocking side. Software-style control arrives as one 18-bit control word written in a single cycle. Transmit bytes are queued in a 64-entry byte FIFO. Received bytes collect in a second 64-entry FIFO, and the host drains it. The serial clock rate comes from outside: every pulse on `sclk_tick` moves the serial clock by one half period. A programmable divider elsewhere produces those pulses.

Each exchange is set by two 24-bit lengths, sampled when the exchange starts. The burst length is the number of bytes clocked on the wire. The transmit length is the number of those bytes taken from the transmit FIFO. Any bytes past the transmit length are sent as zero. Received bytes can be thrown away, which suits transfers that only transmit. Each of the four select lines can be driven automatically during an exchange or held by hand. The lines that are not selected always rest at the inactive level set by the polarity bit.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset the control word reads 0x00010 (only the active-low select bit is set). Both FIFO levels are 0, all four select lines are 1, `spi_sclk` is 0 and `xfer_done` is 0.
- R2: Each FIFO holds up to 64 bytes, and its level is reported on a 7-bit port. A push into a full FIFO is ignored, and so is a pop from an empty one. `rx_data` always shows the oldest stored byte.
- R3: Writing the control word with bit 8 set empties the transmit FIFO. Bit 9 does the same for the receive FIFO. Both bits read back as 0.
- R4: Bit 10 (exchange) becomes 1 only when it is written as 1 in a word that also has bit 0 (enable) and bit 1 (master) set. Otherwise the write starts nothing and bit 10 reads 0.
- R5: An exchange clocks exactly burst-length bytes, with 16 serial clock edges per byte and at most one edge per tick. On completion `xfer_done` pulses for one cycle and bit 10 clears. A burst length of 0 completes without any clock edge.
- R6: The first min(transmit length, burst length) bytes sent come from the transmit FIFO in order. All remaining bytes are 0x00. The transmit FIFO is never popped beyond the transmit length.
- R7: Bit 3 sets the idle clock level. With bit 2 clear, data is valid before the first edge and is sampled on leading edges. With bit 2 set, data changes on leading edges and is sampled on trailing edges.
- R8: With bit 6 set, bytes are shifted least significant bit first in both directions. With bit 6 clear, the most significant bit goes first.
- R9: Each received byte is pushed into the receive FIFO unless bit 15 (discard) is set. When bit 15 is set, the receive level stays unchanged.
- R10: In automatic mode (bit 16 clear), the line chosen by bits 13:12 is active while bit 10 is 1. Active means 0 when bit 4 is set and 1 when bit 4 is clear. All other lines, and every line when idle, sit at the inactive level.
- R11: In manual mode (bit 16 set), the line chosen by bits 13:12 drives the value of bit 17. The other lines sit at the inactive level given by bit 4.
- R12: While transmit bytes are still owed and the transmit FIFO is empty, the engine waits without producing clock edges. It resumes once a byte is pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 18 | Control word to write |
| ctrl_rdata | output | 18 | Current control word |
| burst_len | input | 24 | Total bytes to clock, sampled at start |
| tx_len | input | 24 | Bytes to take from the transmit FIFO, sampled at start |
| sclk_tick | input | 1 | Half-period strobe for the serial clock |
| tx_push | input | 1 | Push `tx_data` into the transmit FIFO |
| tx_data | input | 8 | Byte to queue |
| tx_level | output | 7 | Transmit FIFO fill count |
| rx_pop | input | 1 | Remove the oldest received byte |
| rx_data | output | 8 | Oldest received byte |
| rx_level | output | 7 | Receive FIFO fill count |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 4 | Device select lines |
| xfer_done | output | 1 | One-cycle pulse when an exchange completes |

## Verification
The assertions take for granted that the clock polarity and phase bits stay unchanged while a byte is being shifted. They also assume that neither FIFO is reset in the middle of an exchange. The stimulus writes the mode bits in a separate control write, several cycles before the write that starts an exchange. It then does not touch the control word until `xfer_done` has pulsed. Transfer lengths are kept small enough that neither FIFO can overflow during a randomized exchange.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    localparam int CTRL_W = 18;

    // control word bit positions
    localparam int B_EN    = 0;
    localparam int B_MST   = 1;
    localparam int B_CPHA  = 2;
    localparam int B_CPOL  = 3;
    localparam int B_CSAL  = 4;
    localparam int B_LSB   = 6;
    localparam int B_TXRST = 8;
    localparam int B_RXRST = 9;
    localparam int B_XCH   = 10;
    localparam int B_CSIDX = 12;
    localparam int B_DISC  = 15;
    localparam int B_MAN   = 16;
    localparam int B_LVL   = 17;

    typedef struct packed {
        logic       man_lvl;
        logic       man_cs;
        logic       discard;
        logic [1:0] cs_idx;
        logic       xch;
        logic       lsb;
        logic       cs_al;
        logic       cpol;
        logic       cpha;
        logic       master;
        logic       enable;
    } ctrl_t;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_LOAD,
        ENG_WAIT
    } eng_st_t;

    function automatic ctrl_t ctrl_from_word(logic [CTRL_W-1:0] w);
        ctrl_t c;
        c.enable  = w[B_EN];
        c.master  = w[B_MST];
        c.cpha    = w[B_CPHA];
        c.cpol    = w[B_CPOL];
        c.cs_al   = w[B_CSAL];
        c.lsb     = w[B_LSB];
        c.xch     = w[B_XCH];
        c.cs_idx  = w[B_CSIDX +: 2];
        c.discard = w[B_DISC];
        c.man_cs  = w[B_MAN];
        c.man_lvl = w[B_LVL];
        return c;
    endfunction

    function automatic logic [CTRL_W-1:0] ctrl_to_word(ctrl_t c);
        logic [CTRL_W-1:0] w;
        w             = '0;
        w[B_EN]       = c.enable;
        w[B_MST]      = c.master;
        w[B_CPHA]     = c.cpha;
        w[B_CPOL]     = c.cpol;
        w[B_CSAL]     = c.cs_al;
        w[B_LSB]      = c.lsb;
        w[B_XCH]      = c.xch;
        w[B_CSIDX+:2] = c.cs_idx;
        w[B_DISC]     = c.discard;
        w[B_MAN]      = c.man_cs;
        w[B_LVL]      = c.man_lvl;
        return w;
    endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter  int DEPTH = 64,
    parameter  int W     = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] level
);

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d       = q;
        do_push = push && !flush && (q.cnt != CW'(DEPTH));
        do_pop  = pop && !flush && (q.cnt != '0);
        if (flush) begin
            d = '0;
        end else begin
            if (do_push) d.wr = nxt(q.wr);
            if (do_pop)  d.rd = nxt(q.rd);
            case ({do_push, do_pop})
                2'b10:   d.cnt = q.cnt + 1'b1;
                2'b01:   d.cnt = q.cnt - 1'b1;
                default: d.cnt = q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[q.wr] <= wdata;
    end

    assign rdata = mem_q[q.rd];
    assign level = q.cnt;

    // R2: a push into a full FIFO leaves the level unchanged
    a_r2_full_push_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (level == CW'(DEPTH) && push && !pop && !flush) |=> (level == CW'(DEPTH)));

    // R2: a pop from an empty FIFO leaves it empty
    a_r2_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0 && pop && !push && !flush) |=> (level == '0));

    // R3: a flush empties the FIFO on the next cycle
    a_r3_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0));

endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpol,
    input  logic       cpha,
    input  logic       lsb_first,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       tick,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);

    typedef struct packed {
        logic       active;
        logic [3:0] h;
        logic [7:0] tx;
        logic [7:0] rx;
        logic       sclk;
        logic       mosi;
        logic       done;
    } sh_st_t;

    sh_st_t q, d;
    logic       lead;
    logic [2:0] k;

    function automatic logic [2:0] pos(logic [2:0] idx, logic lsb);
        return lsb ? idx : 3'd7 - idx;
    endfunction

    always_comb begin
        d      = q;
        d.done = 1'b0;
        lead   = ~q.h[0];
        k      = q.h[3:1];
        if (!q.active) d.sclk = cpol;
        if (load) begin
            d.active = 1'b1;
            d.h      = '0;
            d.tx     = load_byte;
            d.mosi   = load_byte[pos(3'd0, lsb_first)];
            d.sclk   = cpol;
        end else if (q.active && tick) begin
            d.sclk = ~q.sclk;
            if (lead ^ cpha) begin
                d.rx[pos(k, lsb_first)] = miso;
            end else if (cpha) begin
                d.mosi = q.tx[pos(k, lsb_first)];
            end else if (k != 3'd7) begin
                d.mosi = q.tx[pos(k + 3'd1, lsb_first)];
            end
            d.h = q.h + 1'b1;
            if (q.h == 4'd15) begin
                d.active = 1'b0;
                d.done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk    = q.sclk;
    assign mosi    = q.mosi;
    assign done    = q.done;
    assign rx_byte = q.rx;

    // R7: after sixteen edges the clock rests at the polarity level
    a_r7_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(q.active) && $stable(cpol)) |-> (sclk == cpol));

    // R5: no clock edge without a tick while shifting
    a_r5_edge_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && !tick && !load) |=> $stable(sclk));

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import spi_eng_pkg::*;
#(
    parameter  int FIFO_DEPTH = 64,
    parameter  int CNT_W      = 24,
    parameter  int NUM_CS     = 4,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_rdata,
    input  logic [CNT_W-1:0]  burst_len,
    input  logic [CNT_W-1:0]  tx_len,
    input  logic              sclk_tick,
    input  logic              tx_push,
    input  logic [7:0]        tx_data,
    output logic [LVL_W-1:0]  tx_level,
    input  logic              rx_pop,
    output logic [7:0]        rx_data,
    output logic [LVL_W-1:0]  rx_level,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs,
    output logic              xfer_done
);

    typedef struct packed {
        eng_st_t          st;
        logic [CNT_W-1:0] burst_rem;
        logic [CNT_W-1:0] xmit_rem;
        ctrl_t            ctrl;
        logic             done;
    } eng_t;

    localparam ctrl_t CTRL_RST = '{cs_al: 1'b1, default: '0};

    eng_t q, d;
    ctrl_t wc;
    logic       tx_flush, rx_flush, tx_pop_i, rx_push_i;
    logic       sh_load, sh_done;
    logic [7:0] load_byte, tx_rdata, sh_rx;
    logic       tx_empty;

    assign tx_empty = (tx_level == '0);

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        wc        = ctrl_from_word(ctrl_wdata);
        tx_flush  = 1'b0;
        rx_flush  = 1'b0;
        tx_pop_i  = 1'b0;
        rx_push_i = 1'b0;
        sh_load   = 1'b0;
        load_byte = '0;
        if (ctrl_wr) begin
            tx_flush   = ctrl_wdata[B_TXRST];
            rx_flush   = ctrl_wdata[B_RXRST];
            d.ctrl     = wc;
            d.ctrl.xch = q.ctrl.xch || (wc.xch && wc.enable && wc.master);
            if (!q.ctrl.xch && d.ctrl.xch) begin
                d.st        = ENG_LOAD;
                d.burst_rem = burst_len;
                d.xmit_rem  = tx_len;
            end
        end
        case (q.st)
            ENG_LOAD: begin
                if (q.burst_rem == '0) begin
                    d.st       = ENG_IDLE;
                    d.ctrl.xch = 1'b0;
                    d.done     = 1'b1;
                end else if (q.xmit_rem != '0) begin
                    if (!tx_empty) begin
                        tx_pop_i   = 1'b1;
                        sh_load    = 1'b1;
                        load_byte  = tx_rdata;
                        d.xmit_rem = q.xmit_rem - 1'b1;
                        d.st       = ENG_WAIT;
                    end
                end else begin
                    sh_load = 1'b1;
                    d.st    = ENG_WAIT;
                end
            end
            ENG_WAIT: begin
                if (sh_done) begin
                    rx_push_i   = !q.ctrl.discard;
                    d.burst_rem = q.burst_rem - 1'b1;
                    d.st        = ENG_LOAD;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ENG_IDLE;
            q.ctrl <= CTRL_RST;
        end else begin
            q <= d;
        end
    end

    byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (tx_flush),
        .push  (tx_push),
        .wdata (tx_data),
        .pop   (tx_pop_i),
        .rdata (tx_rdata),
        .level (tx_level)
    );

    byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rx_flush),
        .push  (rx_push_i),
        .wdata (sh_rx),
        .pop   (rx_pop),
        .rdata (rx_data),
        .level (rx_level)
    );

    spi_bit_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpol      (q.ctrl.cpol),
        .cpha      (q.ctrl.cpha),
        .lsb_first (q.ctrl.lsb),
        .load      (sh_load),
        .load_byte (load_byte),
        .tick      (sclk_tick),
        .miso      (spi_miso),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .done      (sh_done),
        .rx_byte   (sh_rx)
    );

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        localparam logic [1:0] IDX = 2'(i);
        assign spi_cs[i] = q.ctrl.man_cs
            ? ((q.ctrl.cs_idx == IDX) ? q.ctrl.man_lvl : q.ctrl.cs_al)
            : ((q.ctrl.cs_idx == IDX && q.ctrl.xch) ? ~q.ctrl.cs_al : q.ctrl.cs_al);
    end

    assign ctrl_rdata = ctrl_to_word(q.ctrl);
    assign xfer_done  = q.done;

    // R5: completion pulse coincides with exchange bit cleared
    a_r5_done_clears_xch: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> !ctrl_rdata[B_XCH]);

    // R5: remaining burst never grows during an exchange
    a_r5_burst_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ENG_IDLE && $past(q.st) != ENG_IDLE) |-> (q.burst_rem <= $past(q.burst_rem)));

    // R4: a write lacking enable or master cannot start an exchange
    a_r4_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !ctrl_rdata[B_XCH] && !(ctrl_wdata[B_EN] && ctrl_wdata[B_MST]))
        |=> !ctrl_rdata[B_XCH]);

    // R6: once the transmit count is spent the transmit FIFO is not drained
    a_r6_no_extra_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ENG_IDLE && q.xmit_rem == '0 && !ctrl_wr) |=> (tx_level >= $past(tx_level)));

    // R12: waiting for a transmit byte produces no clock edge
    a_r12_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ENG_LOAD && q.burst_rem != '0 && q.xmit_rem != '0 && tx_empty && !ctrl_wr)
        |=> $stable(spi_sclk));

    // R10, R11: at most one select line differs from the inactive level
    a_r10_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(spi_cs ^ {NUM_CS{q.ctrl.cs_al}}));

endmodule

// File: tb/tb_spi_xfer_engine.sv
`timescale 1ns/1ps
module tb_spi_xfer_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [17:0] ctrl_wdata = '0;
    logic [17:0] ctrl_rdata;
    logic [23:0] burst_len = '0;
    logic [23:0] tx_len = '0;
    logic        sclk_tick = 1'b0;
    logic        tx_push = 1'b0;
    logic [7:0]  tx_data = '0;
    logic [6:0]  tx_level;
    logic        rx_pop = 1'b0;
    logic [7:0]  rx_data;
    logic [6:0]  rx_level;
    logic        spi_sclk, spi_mosi, spi_miso;
    logic [3:0]  spi_cs;
    logic        xfer_done;

    always #2 clk = ~clk;

    spi_xfer_engine dut (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata), .burst_len(burst_len), .tx_len(tx_len),
        .sclk_tick(sclk_tick), .tx_push(tx_push), .tx_data(tx_data),
        .tx_level(tx_level), .rx_pop(rx_pop), .rx_data(rx_data),
        .rx_level(rx_level), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_cs(spi_cs), .xfer_done(xfer_done)
    );

    int n_chk = 0;
    int n_fail = 0;

    // bus model state
    logic       cur_cpol = 1'b0, cur_cpha = 1'b0, cur_lsb = 1'b0;
    logic       prev_sclk = 1'b0;
    int         mon_n = 0, mon_k = 0, edge_cnt = 0;
    logic [7:0] mon_acc = '0;
    logic [7:0] mon_bytes [256];
    int         tick_div = 1, tick_cnt = 0;
    logic [7:0] exp_tx [16];

    function automatic logic [7:0] slv(int j);
        return 8'((j * 29 + 11) ^ (j >> 2));
    endfunction

    function automatic logic [17:0] mk_ctrl(logic cpha, logic cpol, logic al, logic lsb,
                                            logic rst, logic xch, logic [1:0] idx,
                                            logic disc, logic man, logic lvl);
        logic [17:0] w = '0;
        w[0] = 1'b1; w[1] = 1'b1; w[2] = cpha; w[3] = cpol; w[4] = al; w[6] = lsb;
        w[8] = rst; w[9] = rst; w[10] = xch; w[13:12] = idx; w[15] = disc;
        w[16] = man; w[17] = lvl;
        return w;
    endfunction

    logic [7:0] cur_slv;
    assign cur_slv  = slv(mon_n);
    assign spi_miso = cur_lsb ? cur_slv[mon_k[2:0]] : cur_slv[3'd7 - mon_k[2:0]];

    always @(negedge clk) begin
        if (spi_sclk != prev_sclk && ctrl_rdata[10]) begin
            edge_cnt = edge_cnt + 1;
            if ((spi_sclk != cur_cpol) ^ cur_cpha) begin
                if (cur_lsb) mon_acc[mon_k[2:0]] = spi_mosi;
                else         mon_acc[3'd7 - mon_k[2:0]] = spi_mosi;
                mon_k = mon_k + 1;
                if (mon_k == 8) begin
                    mon_bytes[mon_n[7:0]] = mon_acc;
                    mon_n = mon_n + 1;
                    mon_k = 0;
                end
            end
        end
        prev_sclk = spi_sclk;
        tick_cnt = tick_cnt + 1;
        if (tick_cnt >= tick_div) begin
            tick_cnt = 0;
            sclk_tick = 1'b1;
        end else begin
            sclk_tick = 1'b0;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr_ctrl(logic [17:0] w);
        @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = w;
        @(negedge clk); ctrl_wr = 1'b0;
    endtask

    task automatic push_tx(logic [7:0] b);
        @(negedge clk); tx_push = 1'b1; tx_data = b;
        @(negedge clk); tx_push = 1'b0;
    endtask

    task automatic pop_rx(output logic [7:0] b);
        @(negedge clk); b = rx_data; rx_pop = 1'b1;
        @(negedge clk); rx_pop = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // transfer context
    logic       x_cpha, x_cpol, x_lsb, x_al, x_disc;
    logic [1:0] x_idx;
    int         x_burst, x_xmit, x_base, x_edge0;

    task automatic begin_xfer(int npush);
        cur_cpol = x_cpol; cur_cpha = x_cpha; cur_lsb = x_lsb;
        wr_ctrl(mk_ctrl(x_cpha, x_cpol, x_al, x_lsb, 1'b1, 1'b0, x_idx, x_disc, 1'b0, 1'b0));
        idle(3);
        chk(spi_sclk == x_cpol, "R7", "idle clock level", spi_sclk, x_cpol);
        for (int i = 0; i < npush; i++) push_tx(exp_tx[i]);
        burst_len = 24'(x_burst); tx_len = 24'(x_xmit);
        x_base = mon_n; x_edge0 = edge_cnt;
        wr_ctrl(mk_ctrl(x_cpha, x_cpol, x_al, x_lsb, 1'b0, 1'b1, x_idx, x_disc, 1'b0, 1'b0));
        chk(spi_cs == (({4{x_al}}) ^ (4'b0001 << x_idx)), "R10", "select during exchange",
            spi_cs, ({4{x_al}}) ^ (4'b0001 << x_idx));
    endtask

    task automatic finish_xfer();
        bit seen = 0;
        logic [7:0] b, e;
        int used;
        for (int c = 0; c < 3000 && !seen; c++) begin
            @(negedge clk);
            if (xfer_done) seen = 1;
        end
        chk(seen, "R5", "done pulse seen", seen, 1);
        chk(ctrl_rdata[10] == 1'b0, "R5", "exchange bit cleared", ctrl_rdata[10], 0);
        chk(edge_cnt - x_edge0 == 16 * x_burst, "R5", "clock edges", edge_cnt - x_edge0, 16 * x_burst);
        chk(mon_n - x_base == x_burst, "R5", "bytes clocked", mon_n - x_base, x_burst);
        for (int i = 0; i < x_burst; i++) begin
            e = (i < x_xmit) ? exp_tx[i] : 8'h00;
            chk(mon_bytes[(x_base + i) % 256] == e, "R6", "mosi byte (R7 R8 mode)",
                mon_bytes[(x_base + i) % 256], e);
        end
        used = (x_xmit < x_burst) ? x_xmit : x_burst;
        chk(int'(tx_level) == x_xmit - used, "R6", "tx bytes left", tx_level, x_xmit - used);
        if (x_disc) begin
            chk(rx_level == 0, "R9", "discarded rx level", rx_level, 0);
        end else begin
            chk(int'(rx_level) == x_burst, "R9", "rx level", rx_level, x_burst);
            for (int i = 0; i < x_burst; i++) begin
                pop_rx(b);
                chk(b == slv(x_base + i), "R8", "received byte", b, slv(x_base + i));
            end
        end
        chk(spi_cs == {4{x_al}}, "R10", "select idle after exchange", spi_cs, {4{x_al}});
    endtask

    initial begin
        logic [7:0] scratch;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) exp_tx[i] = 8'($urandom);
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        chk(ctrl_rdata == 18'h00010, "R1", "control word", ctrl_rdata, 18'h10);
        chk(tx_level == 0, "R1", "tx level", tx_level, 0);
        chk(rx_level == 0, "R1", "rx level", rx_level, 0);
        chk(spi_cs == 4'hF, "R1", "select lines", spi_cs, 4'hF);
        chk(spi_sclk == 1'b0, "R1", "clock", spi_sclk, 0);
        chk(xfer_done == 1'b0, "R1", "done", xfer_done, 0);

        // R2 fill to capacity and one more
        for (int i = 0; i < 65; i++) push_tx(8'(i));
        chk(tx_level == 7'd64, "R2", "tx level at capacity", tx_level, 64);
        rx_pop = 1'b1; idle(1); rx_pop = 1'b0; idle(1);
        chk(rx_level == 0, "R2", "pop from empty", rx_level, 0);

        // R3 reset the transmit FIFO
        wr_ctrl(18'h00110);
        chk(tx_level == 0, "R3", "tx after reset bit", tx_level, 0);
        chk(ctrl_rdata[9:8] == 2'b00, "R3", "reset bits read back", ctrl_rdata[9:8], 0);

        // R4 start without enable/master is ignored
        push_tx(8'hA5);
        burst_len = 24'd1; tx_len = 24'd1;
        wr_ctrl(18'h00410);
        idle(60);
        chk(ctrl_rdata[10] == 1'b0, "R4", "exchange bit without enable", ctrl_rdata[10], 0);
        chk(tx_level == 1, "R4", "tx byte untouched", tx_level, 1);
        wr_ctrl(18'h00111);

        // R11 manual select
        wr_ctrl(mk_ctrl(0, 0, 1, 0, 0, 0, 2'd2, 0, 1, 0));
        chk(spi_cs == 4'b1011, "R11", "manual low, active-low idle", spi_cs, 4'b1011);
        wr_ctrl(mk_ctrl(0, 0, 0, 0, 0, 0, 2'd1, 0, 1, 1));
        chk(spi_cs == 4'b0010, "R11", "manual high, active-high idle", spi_cs, 4'b0010);

        // R5 zero-length burst
        x_cpha = 0; x_cpol = 0; x_lsb = 0; x_al = 1; x_idx = 0; x_disc = 0;
        x_burst = 0; x_xmit = 0; tick_div = 1;
        begin_xfer(0); finish_xfer();

        // R6 directed: mode 0, MSB first, zero padding
        x_burst = 4; x_xmit = 2; x_idx = 3;
        begin_xfer(2); finish_xfer();

        // R12 stall with one byte missing
        x_cpha = 1; x_cpol = 1; x_lsb = 1; x_idx = 1; x_al = 0;
        x_burst = 3; x_xmit = 2; tick_div = 2;
        begin_xfer(1);
        idle(300);
        chk(ctrl_rdata[10] == 1'b1, "R12", "still running while starved", ctrl_rdata[10], 1);
        chk(edge_cnt - x_edge0 == 16, "R12", "edges while starved", edge_cnt - x_edge0, 16);
        push_tx(exp_tx[1]);
        finish_xfer();

        // randomized exchanges covering R7 R8 R9 R10
        for (int t = 0; t < 10; t++) begin
            x_cpha = 1'($urandom); x_cpol = 1'($urandom); x_lsb = 1'($urandom);
            x_al = 1'($urandom); x_idx = 2'($urandom); x_disc = ($urandom % 4) == 0;
            x_burst = 1 + ($urandom % 10);
            x_xmit = $urandom % (x_burst + 3);
            tick_div = 1 + ($urandom % 3);
            for (int i = 0; i < 16; i++) exp_tx[i] = 8'($urandom);
            begin_xfer(x_xmit); finish_xfer();
        end
        scratch = rx_data;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule